// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block holds the word address of a synchronous burst memory and steps it through a four-word burst. It sits between the address pins and the memory array. It captures a fresh external address when one of two address strobes starts an access. It then produces the current word address on every clock. While neither strobe is asserted, the advance input moves the address to the next word of the burst.

There are two kinds of start. A processor-strobe start takes priority. It is gated by all three chip enables, including the master enable. A controller-strobe start is accepted only when the processor strobe is idle. It ignores the master enable and is gated only by the two secondary enables.

Only the low two address bits move during a burst, and they wrap within a group of four. One order-select pin picks the order. With the pin high, the order is interleaved: the start value XOR a running count. With the pin low, the order is linear: the start value plus the count, modulo four. The pin acts combinationally on the output.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where `proc_stb_n`=0, `ce_main_n`=0, `ce_pos`=1 and `ce_neg_n`=0, `word_addr` becomes the sampled `ext_addr` after that edge, and the burst count restarts at zero.
- R2: When `ce_main_n`=1, a low `proc_stb_n` starts nothing. If `ctrl_stb_n` is also 1, `word_addr` is unchanged after the edge.
- R3: On an edge where `ctrl_stb_n`=0, `proc_stb_n`=1, `ce_pos`=1 and `ce_neg_n`=0, the sampled `ext_addr` is captured and the count restarts, whatever the value of `ce_main_n`.
- R4: `adv_n` has no effect on an edge that samples `proc_stb_n`=0. If both strobes are low and the processor start qualifies, the processor start wins.
- R5: On an edge with `adv_n`=0 and both strobes high, the burst count increments by one, modulo four.
- R6: On an edge with no accepted start and no advance, `word_addr` is unchanged. This includes a controller strobe whose secondary enables are inactive.
- R7: While `order_sel`=1 (interleaved), `word_addr[1:0]` equals the captured low bits XOR the count.
- R8: While `order_sel`=0 (linear), `word_addr[1:0]` equals the captured low bits plus the count, modulo four.
- R9: `word_addr` above bit 1 stays at the captured value throughout a burst. After four advances, the address is back at the start word.
- R10: While `rst_n`=0, the address register and the count clear to zero, so `word_addr` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External address to capture |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_pos | input | 1 | Secondary chip enable, active high |
| ce_neg_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| word_addr | output | ADDR_W | Current internal word address |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and that all inputs are settled before the edge. They place no other restriction on strobe or enable combinations. The bench changes inputs only on the falling edge. It draws every control bit independently from a fixed-seed random stream, so overlapping strobes, gated starts and advances during starts all occur. It also flips the order pin in the middle of a burst. Directed sequences cover the two orders from a non-zero start word, the wrap after four advances, and the priority and gating corner cases.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;
endpackage

// File: rtl/burst_start_decode.sv
module burst_start_decode (
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    input  logic adv_n,
    input  logic ce_main_n,
    input  logic ce_pos,
    input  logic ce_neg_n,
    output logic take_proc,
    output logic take_ctrl,
    output logic step
);
    logic side_en;

    always_comb begin
        side_en   = ce_pos && !ce_neg_n;
        take_proc = !proc_stb_n && !ce_main_n && side_en;
        take_ctrl = !ctrl_stb_n && proc_stb_n && side_en;
        step      = !adv_n && proc_stb_n && ctrl_stb_n;
    end

    always_comb begin
        assert (!(take_proc && take_ctrl))
            else $error("AST_ONE_START violated"); // R4
        assert (!(step && (take_proc || take_ctrl)))
            else $error("AST_NO_STEP_ON_START violated"); // R4
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic [ADDR_W-1:0]     base,
    input  logic [BURST_BITS-1:0] count,
    input  logic                  order_sel,
    output logic [ADDR_W-1:0]     addr
);
    import burst_seq_pkg::*;

    logic [BURST_BITS-1:0] low_xor;
    logic [BURST_BITS-1:0] low_add;

    always_comb begin
        low_xor = base[BURST_BITS-1:0] ^ count;
        low_add = base[BURST_BITS-1:0] + count;
        addr    = base;
        if (order_e'(order_sel) == ORDER_INTERLEAVED)
            addr[BURST_BITS-1:0] = low_xor;
        else
            addr[BURST_BITS-1:0] = low_add;
    end

    always_comb begin
        assert (addr[ADDR_W-1:BURST_BITS] == base[ADDR_W-1:BURST_BITS])
            else $error("AST_UPPER_PASS violated"); // R9
        assert ((count != '0) || (addr == base))
            else $error("AST_COUNT_ZERO_IS_BASE violated"); // R7
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W     = 18,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              ce_main_n,
    input  logic              ce_pos,
    input  logic              ce_neg_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] word_addr
);
    localparam logic [BURST_BITS-1:0] CNT_ONE = BURST_BITS'(1);

    typedef struct packed {
        logic [ADDR_W-1:0]     base;
        logic [BURST_BITS-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic take_proc, take_ctrl, step;

    burst_start_decode i_decode (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .ce_main_n  (ce_main_n),
        .ce_pos     (ce_pos),
        .ce_neg_n   (ce_neg_n),
        .take_proc  (take_proc),
        .take_ctrl  (take_ctrl),
        .step       (step)
    );

    always_comb begin
        st_d = st_q;
        if (take_proc || take_ctrl) begin
            st_d.base = ext_addr;
            st_d.cnt  = '0;
        end else if (step) begin
            st_d.cnt  = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    burst_order_map #(
        .ADDR_W     (ADDR_W),
        .BURST_BITS (BURST_BITS)
    ) i_map (
        .base      (st_q.base),
        .count     (st_q.cnt),
        .order_sel (order_sel),
        .addr      (word_addr)
    );

    AST_PROC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && !ce_main_n && ce_pos && !ce_neg_n)
        |=> (st_q.base == $past(ext_addr) && st_q.cnt == '0)); // R1
    AST_MASTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_main_n && ctrl_stb_n && !proc_stb_n)
        |=> ($stable(st_q.base) && $stable(st_q.cnt))); // R2
    AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && proc_stb_n && ce_pos && !ce_neg_n)
        |=> (st_q.base == $past(ext_addr) && st_q.cnt == '0)); // R3
    AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_n && proc_stb_n && ctrl_stb_n)
        |=> (st_q.cnt == BURST_BITS'($past(st_q.cnt) + CNT_ONE)
             && $stable(st_q.base))); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && proc_stb_n && ctrl_stb_n)
        |=> ($stable(st_q.base) && $stable(st_q.cnt))); // R6
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (word_addr == '0)); // R10
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
    logic ce_main_n = 1'b0, ce_pos = 1'b1, ce_neg_n = 1'b0, order_sel = 1'b1;
    logic [AW-1:0] word_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt  = '0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .ce_main_n(ce_main_n), .ce_pos(ce_pos), .ce_neg_n(ce_neg_n),
        .order_sel(order_sel), .word_addr(word_addr)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] c, logic ord);
        logic [AW-1:0] r;
        r = b;
        r[1:0] = ord ? (b[1:0] ^ c) : 2'(b[1:0] + c);
        return r;
    endfunction

    task automatic check(string tag, logic [AW-1:0] expv);
        n_checks++;
        if (word_addr !== expv) begin
            n_fail++;
            $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // drive at falling edge, model the rising edge, check at next falling edge
    task automatic cyc(logic p, logic c, logic a, logic m, logic cp, logic cn,
                       logic [AW-1:0] ad, string tag);
        logic side;
        proc_stb_n = p; ctrl_stb_n = c; adv_n = a;
        ce_main_n = m; ce_pos = cp; ce_neg_n = cn; ext_addr = ad;
        side = cp && !cn;
        @(posedge clk);
        if (!p && !m && side) begin m_base = ad; m_cnt = 2'd0; end
        else if (!c && p && side) begin m_base = ad; m_cnt = 2'd0; end
        else if (!a && p && c) m_cnt = m_cnt + 2'd1;
        @(negedge clk);
        check(tag, exp_addr(m_base, m_cnt, order_sel));
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        check("R10 reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", '0);

        // interleaved from start word 1: 1,0,3,2 then wrap
        order_sel = 1'b1;
        cyc(0,1,0, 0,1,0, 18'h2AB5, "R1 proc capture / R4 adv ignored");
        cyc(1,1,0, 0,1,0, 18'h0000, "R5 R7 interleaved step1");
        cyc(1,1,0, 0,1,0, 18'h0000, "R7 interleaved step2");
        cyc(1,1,0, 0,1,0, 18'h0000, "R7 interleaved step3");
        cyc(1,1,0, 0,1,0, 18'h0000, "R9 wrap to start");
        check("R9 wrap value", 18'h2AB5);
        cyc(1,1,1, 0,1,0, 18'h3FFF, "R6 hold");
        // linear from start word 1: 1,2,3,0
        order_sel = 1'b0;
        cyc(1,0,1, 1,1,0, 18'h1005, "R3 ctrl capture with master off");
        cyc(1,1,0, 0,1,0, 18'h0, "R8 linear step1");
        check("R8 linear 2", 18'h1006);
        cyc(1,1,0, 0,1,0, 18'h0, "R8 linear step2");
        cyc(1,1,0, 0,1,0, 18'h0, "R8 linear step3");
        check("R8 R9 linear wrap low bits", 18'h1004);
        order_sel = 1'b1;
        #1 check("R7 order flip live", exp_addr(m_base, m_cnt, 1'b1));
        cyc(0,1,0, 1,1,0, 18'h3333, "R2 master blocks proc");
        cyc(0,0,0, 0,1,0, 18'h0ABC, "R4 proc wins over ctrl");
        cyc(1,0,0, 0,0,0, 18'h1111, "R6 ctrl gated by secondary enable");

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) order_sel = ~order_sel;
            cyc($urandom_range(0,3) != 0, $urandom_range(0,3) != 0, 1'($urandom),
                $urandom_range(0,6) == 0, $urandom_range(0,6) != 0, $urandom_range(0,6) == 0,
                AW'($urandom), order_sel ? "R7 random" : "R8 random");
        end
        finish_run();
    end
endmodule